// File: doc/BRIEF.md
# Tile Row Reducer with Boundary Delay Line

This block is the reduction stage behind a 6×3 grid of processing elements. Each element runs three threads, so the grid hands it 54 signed products every step. The block serves a 3×3, stride-1 convolution whose input is cut into bands of six rows. At each step the grid holds one 6-row by 3-column window of one band.

The first stage has fixed wiring. It adds the products of equal thread index across the three elements of a row, which gives 18 partial sums. The second stage combines these into output rows. Four output rows lie wholly inside the current band and complete in the same step. Two output rows straddle the band and the band below it. For these rows the block pushes one or two partial sums into a delay line. The delay line's length equals the number of column positions per band and is set at run time. The stored sums are added back when the same column position of the next band arrives. Nothing leaves the block for external storage.

Loading a new length restarts the block at the first band of an image. The delay line is cleared at the same time.

Top module: `tile_row_reducer`

## Requirements
- R1: While reset is asserted and after it is released, `outValid` and `outMask` are 0 until the first accepted step.
- R2: An output appears in the cycle after each cycle with `inValid` high, and only then.
- R3: Product k of `inProd` (bits k*PW upward, two's complement) belongs to row r, element c, thread t with k = (r*3+c)*3+t. Partial sum s[r][t] is the sum over c of those products.
- R4: Lanes 2 to 5 of `outData` (lane L at bits L*OW upward, signed) carry s[L-2][0] + s[L-1][1] + s[L][2]. These are the four output rows lying wholly inside the band.
- R5: After the first band, lane 0 carries s[4][0] + s[5][1] from the step `cfgLen` accepted steps earlier, plus the current s[0][2]. Lane 1 carries s[5][0] from that earlier step, plus the current s[0][1] + s[1][2].
- R6: For the first `cfgLen` accepted steps after a load (the first band), lanes 0 and 1 read zero and `outMask` is 6'b111100. Their sums are only stored.
- R7: `cfgLoad` with `inValid` low sets the delay length to `cfgLen` (legal range 1 to MAX_LEN). It clears the stored sums and restarts at the first band, even in the middle of a band.
- R8: Cycles with `inValid` low do not advance the column position or the delay line. Gaps between steps leave every result unchanged.
- R9: Bit L of `outMask` is set exactly when lane L holds a finished output. The value is 6'b111111 after the first band, and all zeros whenever `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgLoad | input | 1 | Load delay length and restart (honoured when inValid is low) |
| cfgLen | input | $clog2(MAX_LEN+1) | Column positions per band, 1 to MAX_LEN |
| inValid | input | 1 | A product set is present this cycle |
| inProd | input | 54*PW | 54 signed products, index (r*3+c)*3+t |
| outValid | output | 1 | Output lanes hold the result of the previous step |
| outMask | output | 6 | Per-lane finished flag |
| outData | output | 6*(PW+4) | Six signed output values |

## Verification
The assertions assume the following about the inputs:
- `cfgLoad` never coincides with `inValid`.
- `cfgLen` always lies in 1 to MAX_LEN.
- Each image is fed band by band and column by column, so exactly `cfgLen` steps form one band.

The stimulus keeps to these rules. It reconfigures only in idle cycles and with legal lengths, including both ends of the range. It abandons one image part-way through a band before loading the next. The bench compares every lane against a direct convolution of random activations and weights. Idle gaps are inserted between steps of one image.

// File: rtl/trr_pkg.sv
package trr_pkg;
  localparam int TILE_ROWS = 6;
  localparam int ROW_PES   = 3;
  localparam int THREADS   = 3;
  localparam int LANES     = TILE_ROWS;
  localparam int NPROD     = TILE_ROWS * ROW_PES * THREADS;

  typedef struct packed {
    logic step;       // accept one product set
    logic flush;      // clear delay line, restart at first band
    logic firstBand;  // boundary lanes are store-only
    logic rewind;     // current step is the last column of a band
  } trr_strobe_t;
endpackage

// File: rtl/trr_row_adder.sv
module trr_row_adder
  import trr_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic [ROW_PES*THREADS*PW-1:0] rowProd,
  input  logic                          unusedTie,
  output logic [THREADS*(PW+2)-1:0]     rowSum
);
  localparam int SW = PW + 2;

  for (genvar t = 0; t < THREADS; t++) begin : g_thread
    logic signed [SW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int c = 0; c < ROW_PES; c++)
        acc = acc + SW'($signed(rowProd[(c*THREADS+t)*PW +: PW]));
    end
    assign rowSum[t*SW +: SW] = acc;
  end

  logic tieSink;
  assign tieSink = unusedTie;
endmodule

// File: rtl/trr_ctrl.sv
module trr_ctrl
  import trr_pkg::*;
#(
  parameter int MAX_LEN = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgLoad,
  input  logic [$clog2(MAX_LEN+1)-1:0]   cfgLen,
  input  logic                           inValid,
  output trr_strobe_t                    stb
);
  localparam int LW = $clog2(MAX_LEN + 1);

  logic [LW-1:0] lenReg;
  logic [LW-1:0] colCnt;
  logic          firstBand;
  logic          flush;
  logic          lastCol;

  assign flush   = cfgLoad && !inValid;
  assign lastCol = (colCnt + LW'(1)) >= lenReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg    <= LW'(MAX_LEN);
      colCnt    <= '0;
      firstBand <= 1'b1;
    end else if (flush) begin
      lenReg    <= cfgLen;
      colCnt    <= '0;
      firstBand <= 1'b1;
    end else if (inValid) begin
      if (lastCol) begin
        colCnt    <= '0;
        firstBand <= 1'b0;
      end else begin
        colCnt <= colCnt + LW'(1);
      end
    end
  end

  always_comb begin
    stb.step      = inValid;
    stb.flush     = flush;
    stb.firstBand = firstBand;
    stb.rewind    = inValid && lastCol;
  end
endmodule

// File: rtl/trr_datapath.sv
module trr_datapath
  import trr_pkg::*;
#(
  parameter int PW      = 16,
  parameter int MAX_LEN = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  trr_strobe_t             stb,
  input  logic [NPROD*PW-1:0]     inProd,
  output logic                    outValid,
  output logic [LANES-1:0]        outMask,
  output logic [LANES*(PW+4)-1:0] outData
);
  localparam int SW = PW + 2;
  localparam int OW = PW + 4;
  localparam int AW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam int ROW_BITS = ROW_PES * THREADS * PW;

  logic [THREADS*SW-1:0] rowSumFlat [TILE_ROWS];
  logic signed [OW-1:0]  ext [TILE_ROWS][THREADS];

  for (genvar r = 0; r < TILE_ROWS; r++) begin : g_row
    trr_row_adder #(.PW(PW)) u_rowAdd (
      .rowProd  (inProd[r*ROW_BITS +: ROW_BITS]),
      .unusedTie(1'b0),
      .rowSum   (rowSumFlat[r])
    );
    for (genvar t = 0; t < THREADS; t++) begin : g_ext
      assign ext[r][t] = OW'($signed(rowSumFlat[r][t*SW +: SW]));
    end
  end

  // boundary delay line, circular with run-time wrap
  logic signed [OW-1:0] holdLo [MAX_LEN];
  logic signed [OW-1:0] holdHi [MAX_LEN];
  logic [AW-1:0]        ptr;
  logic signed [OW-1:0] oldLo, oldHi;

  assign oldLo = holdLo[ptr];
  assign oldHi = holdHi[ptr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      for (int i = 0; i < MAX_LEN; i++) begin
        holdLo[i] <= '0;
        holdHi[i] <= '0;
      end
    end else if (stb.flush) begin
      ptr <= '0;
      for (int i = 0; i < MAX_LEN; i++) begin
        holdLo[i] <= '0;
        holdHi[i] <= '0;
      end
    end else if (stb.step) begin
      holdLo[ptr] <= ext[TILE_ROWS-2][0] + ext[TILE_ROWS-1][1];
      holdHi[ptr] <= ext[TILE_ROWS-1][0];
      ptr         <= stb.rewind ? '0 : ptr + 1'b1;
    end
  end

  logic signed [OW-1:0] lane [LANES];
  always_comb begin
    lane[0] = oldLo + ext[0][2];
    lane[1] = oldHi + ext[0][1] + ext[1][2];
    for (int k = 0; k < TILE_ROWS - 2; k++)
      lane[k+2] = ext[k][0] + ext[k+1][1] + ext[k+2][2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outMask  <= '0;
      outData  <= '0;
    end else begin
      outValid <= stb.step;
      if (stb.step) begin
        outMask <= stb.firstBand ? {{(LANES-2){1'b1}}, 2'b00} : {LANES{1'b1}};
        for (int l = 0; l < LANES; l++)
          outData[l*OW +: OW] <= (stb.firstBand && l < 2) ? '0 : lane[l];
      end else begin
        outMask <= '0;
      end
    end
  end
endmodule

// File: rtl/tile_row_reducer.sv
module tile_row_reducer
  import trr_pkg::*;
#(
  parameter int PW      = 16,
  parameter int MAX_LEN = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgLoad,
  input  logic [$clog2(MAX_LEN+1)-1:0] cfgLen,
  input  logic                         inValid,
  input  logic [54*PW-1:0]             inProd,
  output logic                         outValid,
  output logic [5:0]                   outMask,
  output logic [6*(PW+4)-1:0]          outData
);
  trr_strobe_t stb;

  trr_ctrl #(.MAX_LEN(MAX_LEN)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cfgLoad(cfgLoad),
    .cfgLen (cfgLen),
    .inValid(inValid),
    .stb    (stb)
  );

  trr_datapath #(.PW(PW), .MAX_LEN(MAX_LEN)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inProd  (inProd),
    .outValid(outValid),
    .outMask (outMask),
    .outData (outData)
  );
endmodule

// File: rtl/trr_checker.sv
module trr_checker #(
  parameter int MAX_LEN = 16,
  parameter int OW      = 20
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         cfgLoad,
  input logic [$clog2(MAX_LEN+1)-1:0] cfgLen,
  input logic                         inValid,
  input logic                         outValid,
  input logic [5:0]                   outMask,
  input logic [2*OW-1:0]              edgeLanes
);
  localparam int LW = $clog2(MAX_LEN + 1);

  // outputs seen since the last load, saturating just past the length
  logic [LW:0]   outCnt;
  logic [LW-1:0] lenSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outCnt  <= '0;
      lenSeen <= LW'(MAX_LEN);
    end else if (cfgLoad && !inValid) begin
      outCnt  <= '0;
      lenSeen <= cfgLen;
    end else if (outValid && outCnt <= {1'b0, lenSeen}) begin
      outCnt <= outCnt + 1'b1;
    end
  end

  a_r2_output_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r9_idle_mask: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> outMask == 6'b000000);

  a_r9_core_lanes: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outMask[5:2] == 4'hF);

  a_r6_first_band: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCnt < {1'b0, lenSeen}) |-> (outMask[1:0] == 2'b00 && edgeLanes == '0));

  a_r5_later_band: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCnt >= {1'b0, lenSeen}) |-> outMask[1:0] == 2'b11);
endmodule

bind tile_row_reducer trr_checker #(.MAX_LEN(MAX_LEN), .OW(PW+4)) u_trrChecker (
  .clk      (clk),
  .rstN     (rstN),
  .cfgLoad  (cfgLoad),
  .cfgLen   (cfgLen),
  .inValid  (inValid),
  .outValid (outValid),
  .outMask  (outMask),
  .edgeLanes(outData[2*(PW+4)-1:0])
);

// File: tb/test_tile_row_reducer.sv
module test_tile_row_reducer;
  localparam int CLK_PERIOD = 10;
  localparam int PW   = 16;
  localparam int OW   = PW + 4;
  localparam int MAXL = 16;
  localparam int LW   = $clog2(MAXL + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic [LW-1:0] cfgLen = '0;
  logic inValid = 1'b0;
  logic [54*PW-1:0] inProd = '0;
  logic outValid;
  logic [5:0] outMask;
  logic [6*OW-1:0] outData;

  int nChecks = 0;
  int nFails  = 0;
  int img [24][20];
  int wt  [3][3];
  bit expValid = 1'b0;
  bit [5:0] expMask = '0;
  int expLane [6];
  string ctx = "";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_row_reducer #(.PW(PW), .MAX_LEN(MAXL)) i_tile_row_reducer (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgLen(cfgLen),
    .inValid(inValid), .inProd(inProd),
    .outValid(outValid), .outMask(outMask), .outData(outData)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int golden(input int r, input int j);
    int s = 0;
    for (int t = 0; t < 3; t++)
      for (int c = 0; c < 3; c++)
        s += img[r+t][j+c] * wt[t][c];
    return s;
  endfunction

  // compare outputs against the expectation for the previous edge
  task automatic compare_now();
    chk("R2", "outValid", int'(outValid), int'(expValid));
    chk({"R9 ", ctx}, "outMask", int'(outMask), int'(expMask));
    if (expValid)
      for (int l = 0; l < 6; l++)
        chk(l < 2 ? {"R5 R6 ", ctx} : {"R3 R4 ", ctx}, $sformatf("lane%0d", l),
            int'($signed(outData[l*OW +: OW])), expLane[l]);
  endtask

  task automatic idle_cycle();
    inValid = 1'b0; cfgLoad = 1'b0;
    expValid = 1'b0; expMask = '0;
    @(negedge clk); compare_now();
  endtask

  task automatic load_len(input int len);
    cfgLoad = 1'b1; cfgLen = LW'(len); inValid = 1'b0;
    expValid = 1'b0; expMask = '0;
    @(negedge clk); compare_now();
    cfgLoad = 1'b0;
  endtask

  task automatic step(input int b, input int j);
    inValid = 1'b1;
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 3; c++)
        for (int t = 0; t < 3; t++)
          inProd[((r*3+c)*3+t)*PW +: PW] = PW'(img[6*b+r][j+c] * wt[t][c]);
    expValid = 1'b1;
    expMask  = (b == 0) ? 6'b111100 : 6'b111111;
    for (int l = 0; l < 6; l++)
      expLane[l] = (b == 0 && l < 2) ? 0 : golden(6*b - 2 + l, j);
    @(negedge clk); compare_now();
  endtask

  task automatic run_image(input int w, input int bands, input bit gaps,
                           input string tag, input int maxSteps);
    int n = 0;
    ctx = tag;
    for (int r = 0; r < 24; r++)
      for (int c = 0; c < 20; c++)
        img[r][c] = $urandom_range(0, 15);
    for (int t = 0; t < 3; t++)
      for (int c = 0; c < 3; c++)
        wt[t][c] = int'($urandom_range(0, 15)) - 8;
    load_len(w - 2);
    for (int b = 0; b < bands; b++)
      for (int j = 0; j < w - 2; j++) begin
        if (n < maxSteps) begin
          step(b, j);
          n++;
          if (gaps && (j % 2 == 0)) idle_cycle();
        end
      end
    idle_cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "outValid in reset", int'(outValid), 0);
    chk("R1", "outMask in reset", int'(outMask), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "outValid after reset", int'(outValid), 0);
    chk("R1", "outMask after reset", int'(outMask), 0);

    run_image(8, 3, 1'b0, "main", 1000);
    run_image(10, 2, 1'b0, "R7 abandoned", 5);
    run_image(5, 3, 1'b1, "R7 R8 gaps", 1000);
    run_image(MAXL + 2, 2, 1'b0, "R7 max length", 1000);
    run_image(3, 3, 1'b1, "R7 R8 min length", 1000);
    run_image(9, 4, 1'b0, "R6 R5 four bands", 1000);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule